// File: doc/BRIEF.md
# Overlapping Zero-One-One Pattern Detector

This block watches one serial bit per clock and reports each completion of the pattern "0, then 1, then 1". After a find it does not stop. It keeps searching, so a new pattern can start in the cycle right after a find. Both outputs come from the same four-state machine. The first is a registered flag, decoded only from a dedicated "found" state. The second is a combinational flag, raised in the cycle whose input completes the pattern. The combinational flag therefore leads the registered one by one clock.

The four states are held one-hot and are also brought out on a port, so that the present position in the search can be observed. The input is assumed to be synchronous to the clock already. A synchronous active-high reset returns the search to its start.

Top module: `trio_detect`

## Requirements
- R1: When `rst` is high at a rising edge, the next cycle shows `state_vec` = 4'b0001 (idle), with `hit_moore` and `hit_mealy` both low.
- R2: In idle (`state_vec` bit 0), a 1 on `din` keeps the machine in idle. A 0 moves it to seen-zero (bit 1).
- R3: In seen-zero (bit 1), a 0 keeps the machine in seen-zero. A 1 moves it to seen-zero-one (bit 2).
- R4: In seen-zero-one (bit 2), a 1 moves the machine to found (bit 3). A 0 moves it back to seen-zero (bit 1).
- R5: In found (bit 3), a 0 moves the machine to seen-zero (bit 1). A 1 moves it to idle (bit 0).
- R6: `hit_moore` is high exactly when the machine is in found. It is therefore high for one cycle per detection and never for two cycles in a row.
- R7: `hit_mealy` is high exactly when the machine is in seen-zero-one and `din` is 1 in the same cycle.
- R8: Outside reset, exactly one bit of `state_vec` is set in every cycle.
- R9: Each cycle with `hit_mealy` high is followed by a cycle with `hit_moore` high. Each cycle with `hit_moore` high follows a cycle with `hit_mealy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial input bit, synchronous to clk |
| hit_moore | output | 1 | Registered detect flag, high while in found |
| hit_mealy | output | 1 | Combinational detect flag, high on the completing input |
| state_vec | output | 4 | One-hot state: bit0 idle, bit1 seen-zero, bit2 seen-zero-one, bit3 found |

## Verification
The hardest situation to reach is the exit from found. A 1 there must reset the search, while a 0 must restart it at seen-zero. Both exits must also be exercised right after a mid-stream reset. A stream that merely wanders rarely produces "0111" or "0110" at chosen points. The bench therefore sweeps every 8-bit input word after a reset, which places each state and each exit at every cycle offset. It then drives a long pseudo-random stream with occasional resets. Expected states come from a count of the 1s seen since the most recent 0.

// File: rtl/trio_pkg.sv
package trio_pkg;

    localparam int unsigned ST_COUNT    = 4;
    localparam int unsigned IX_IDLE     = 0;
    localparam int unsigned IX_ZERO     = 1;
    localparam int unsigned IX_ZERO_ONE = 2;
    localparam int unsigned IX_FOUND    = 3;

    typedef logic [ST_COUNT-1:0] st_vec_t;

    function automatic st_vec_t hot(input int unsigned idx);
        st_vec_t v;
        v      = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    localparam st_vec_t ST_RESET = hot(IX_IDLE);

    typedef struct packed {
        logic moore;
        logic mealy;
    } flags_t;

endpackage

// File: rtl/trio_next.sv
module trio_next
    import trio_pkg::*;
(
    input  st_vec_t cur,
    input  logic    bit_in,
    output st_vec_t nxt
);
    always_comb begin
        nxt              = '0;
        // idle is re-entered on a 1 from idle or from found
        nxt[IX_IDLE]     = bit_in & (cur[IX_IDLE] | cur[IX_FOUND]);
        // any 0 restarts the search at seen-zero
        nxt[IX_ZERO]     = ~bit_in & (|cur);
        nxt[IX_ZERO_ONE] = bit_in & cur[IX_ZERO];
        nxt[IX_FOUND]    = bit_in & cur[IX_ZERO_ONE];
    end
endmodule

// File: rtl/trio_state_reg.sv
module trio_state_reg
    import trio_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  st_vec_t nxt,
    output st_vec_t cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= ST_RESET;
        else     cur <= nxt;
    end
endmodule

// File: rtl/trio_flags.sv
module trio_flags
    import trio_pkg::*;
(
    input  logic   in_found,
    input  logic   in_zero_one,
    input  logic   bit_in,
    output flags_t fl
);
    always_comb begin
        fl.moore = in_found;
        fl.mealy = in_zero_one & bit_in;
    end
endmodule

// File: rtl/trio_detect.sv
module trio_detect
    import trio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                din,
    output logic                hit_moore,
    output logic                hit_mealy,
    output logic [ST_COUNT-1:0] state_vec
);
    st_vec_t cur_st;
    st_vec_t nxt_st;
    flags_t  fl;

    trio_next u_next (
        .cur    (cur_st),
        .bit_in (din),
        .nxt    (nxt_st)
    );

    trio_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_st),
        .cur (cur_st)
    );

    trio_flags u_flags (
        .in_found    (cur_st[IX_FOUND]),
        .in_zero_one (cur_st[IX_ZERO_ONE]),
        .bit_in      (din),
        .fl          (fl)
    );

    assign hit_moore = fl.moore;
    assign hit_mealy = fl.mealy;
    assign state_vec = cur_st;
endmodule

// File: rtl/trio_detect_chk.sv
module trio_detect_chk
    import trio_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                din,
    input logic                hit_moore,
    input logic                hit_mealy,
    input logic [ST_COUNT-1:0] state_vec
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (state_vec == ST_RESET) && !hit_moore && !hit_mealy); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (state_vec[IX_IDLE] && din) |=> state_vec[IX_IDLE]); // R2
    AST_IDLE_LEAVE: assert property (@(posedge clk) disable iff (rst) (state_vec[IX_IDLE] && !din) |=> state_vec[IX_ZERO]); // R2
    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst) (state_vec[IX_ZERO] && !din) |=> state_vec[IX_ZERO]); // R3
    AST_ZERO_ADVANCE: assert property (@(posedge clk) disable iff (rst) (state_vec[IX_ZERO] && din) |=> state_vec[IX_ZERO_ONE]); // R3
    AST_ZERO_ONE_BACK: assert property (@(posedge clk) disable iff (rst) (state_vec[IX_ZERO_ONE] && !din) |=> state_vec[IX_ZERO]); // R4
    AST_FOUND_RETRY: assert property (@(posedge clk) disable iff (rst) (state_vec[IX_FOUND] && !din) |=> state_vec[IX_ZERO]); // R5
    AST_FOUND_CLEAR: assert property (@(posedge clk) disable iff (rst) (state_vec[IX_FOUND] && din) |=> state_vec[IX_IDLE]); // R5
    AST_MOORE_PULSE: assert property (@(posedge clk) disable iff (rst) hit_moore |=> !hit_moore); // R6
    AST_MEALY_ADVANCE: assert property (@(posedge clk) disable iff (rst) hit_mealy |=> state_vec[IX_FOUND]); // R7
    AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst) $countones(state_vec) == 1); // R8
    AST_MEALY_LEADS: assert property (@(posedge clk) disable iff (rst) hit_mealy |=> hit_moore); // R9
endmodule

bind trio_detect trio_detect_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .hit_moore (hit_moore),
    .hit_mealy (hit_mealy),
    .state_vec (state_vec)
);

// File: tb/trio_detect_test.sv
module trio_detect_test;
    localparam int CLK_PERIOD = 10;
    localparam int SWEEP_BITS = 8;
    localparam int RAND_CYCLES = 4000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b1;
    logic       hit_moore;
    logic       hit_mealy;
    logic [3:0] state_vec;

    int checks = 0;
    int errors = 0;

    // reference: has a 0 been seen since reset, and how many 1s since the last 0
    bit  seen_zero = 0;
    int  ones_run  = 0;
    bit  prev_rst  = 1;
    bit  prev_mealy = 0;
    bit  done = 0;

    trio_detect uut (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .hit_moore (hit_moore),
        .hit_mealy (hit_mealy),
        .state_vec (state_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] model_state();
        if (!seen_zero)    return 4'b0001;
        if (ones_run == 0) return 4'b0010;
        if (ones_run == 1) return 4'b0100;
        if (ones_run == 2) return 4'b1000;
        return 4'b0001;
    endfunction

    function automatic string tag_of(input logic [3:0] s);
        case (s)
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0100: return "R4";
            default: return "R5";
        endcase
    endfunction

    string last_tag = "R1";

    task automatic step(input bit d, input bit r);
        logic [3:0] exp_st;
        bit exp_moore;
        bit exp_mealy;
        @(negedge clk);
        din = d;
        rst = r;
        #(CLK_PERIOD/4);
        if (!r && !done) begin
            exp_st    = model_state();
            exp_moore = seen_zero && (ones_run == 2);
            exp_mealy = seen_zero && (ones_run == 1) && d;
            if (prev_rst) begin
                check(state_vec == 4'b0001 && !hit_moore, "R1", state_vec, 4'b0001);
            end else begin
                check(state_vec == exp_st, last_tag, state_vec, exp_st);
                check(hit_moore == prev_mealy, "R9", {3'b0, hit_moore}, {3'b0, prev_mealy});
            end
            check($countones(state_vec) == 1, "R8", state_vec, exp_st);
            check(hit_moore == exp_moore, "R6", {3'b0, hit_moore}, {3'b0, exp_moore});
            check(hit_mealy == exp_mealy, "R7", {3'b0, hit_mealy}, {3'b0, exp_mealy});
            last_tag   = tag_of(exp_st);
            prev_mealy = hit_mealy;
        end else begin
            prev_mealy = 0;
            last_tag   = "R1";
        end
        @(posedge clk);
        prev_rst = r;
        if (r) begin
            seen_zero = 0;
            ones_run  = 0;
        end else if (!d) begin
            seen_zero = 1;
            ones_run  = 0;
        end else if (ones_run < 3) begin
            ones_run++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned lfsr;
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        // sweep every word after a reset, least significant bit first
        for (int w = 0; w < (1 << SWEEP_BITS); w++) begin
            step(1'b1, 1'b1);
            for (int b = 0; b < SWEEP_BITS; b++) step(w[b], 1'b0);
        end
        // directed: found then 1 (R5 to idle), found then 0 (R5 to seen-zero)
        step(1'b0, 1'b1);
        begin
            bit pat [10] = '{0, 1, 1, 1, 0, 1, 1, 0, 1, 1};
            for (int i = 0; i < 10; i++) step(pat[i], 1'b0);
        end
        // long random stream with sparse resets
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < RAND_CYCLES; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[3], (lfsr[15:9] == 7'd0));
        end
        step(1'b1, 1'b0);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule